// File: doc/BRIEF.md
# Flicker-Balanced Beacon Frame Encoder

The block turns a frame request (an 8-bit frame type and a 128-bit identifier) into a 256-bit polar codeword. It then sends that codeword one bit at a time to an LED modulator. The 158-bit payload has four fields: a fixed preamble, the type, the identifier and a CRC-16 that the block computes itself. The payload is whitened with an additive LFSR keystream and placed into the information positions of a length-256 polar code. The remaining positions are frozen to zero, and the vector is run through eight butterfly stages.

No run-length-limited line code follows the transform. Light-level balance comes only from the scrambler and the polar transform, which keeps the code rate at 158/256. A one-frame staging register sits between the request side and the serializer. A new frame can therefore be accepted while the previous codeword is still being shifted out, and back-to-back codewords leave without a gap.

Top module: `beacon_frame_enc`

## Requirements
- R1: Payload bit order is preamble (6 bits, default 101101), type (8), identifier (128), then CRC (16), each field most significant bit first. The CRC uses polynomial 0x1021 and start value 0xFFFF, is computed MSB-first over the first 142 payload bits, and has no final inversion.
- R2: Payload bit j is XORed with keystream bit k_j. A 7-bit register r starts at 1111111 for every frame. For each bit, k = r[6]^r[3], then r becomes {r[5:0], k}.
- R3: The 158 information indices are the codeword indices with the most ones in their 8-bit binary form, ties going to the larger index. The other 98 indices carry 0. Scrambled payload bit j goes to the j-th smallest information index.
- R4: Codeword bit x[i] is the XOR of u[j] over all j whose binary ones include every one of i, that is (j & i) == i.
- R5: Codeword bit 0 is on tx_bit once tx_valid rises. Each sym_tick cycle advances to the next index, and tx_bit holds its value between ticks.
- R6: tx_valid stays high for exactly 256 sym_tick cycles of a codeword and drops after the last one when no frame is staged.
- R7: frame_start is taken only while busy is low. While busy is high, frame_start and the frame inputs have no effect, so the requester holds them.
- R8: If a frame is staged when the last tick of a codeword arrives, the next codeword's bit 0 appears on the following cycle and tx_valid does not drop.
- R9: After reset, busy and tx_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Frame request, taken when busy is low |
| frame_type | input | 8 | Frame type field |
| frame_id | input | 128 | Identifier field |
| busy | output | 1 | Staging register occupied |
| sym_tick | input | 1 | Symbol pulse that advances the serial output |
| tx_bit | output | 1 | Current codeword bit |
| tx_valid | output | 1 | A codeword is being sent |

## Verification
The bench builds the block with its default parameters: 256-bit code, 128-bit identifier, 8-bit type and 6-bit preamble. This is the one configuration where the frozen set, CRC, keystream and butterfly network must all match together for a codeword to compare equal. Four frames of different bit density are sent with different gaps between ticks, which exercises the hold-between-ticks rule. A directed sequence then stages a second frame behind a running codeword and offers a third frame while busy. This brings the seamless codeword-to-codeword handover and the ignored request within reach.

// File: rtl/beacon_enc_pkg.sv
package beacon_enc_pkg;

  localparam int unsigned CRC_W     = 16;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
  localparam int unsigned LFSR_W    = 7;
  localparam logic [6:0]  LFSR_SEED = 7'h7F;

  // One MSB-first CRC step
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  // Keystream bit for the current LFSR state (x^7 + x^4 + 1)
  function automatic logic lfsr_out(input logic [6:0] s);
    return s[6] ^ s[3];
  endfunction

  function automatic logic [6:0] lfsr_next(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[3]};
  endfunction

endpackage

// File: rtl/beacon_frame_asm.sv
module beacon_frame_asm
  import beacon_enc_pkg::*;
#(
  parameter int unsigned PRE_W    = 6,
  parameter int unsigned TYPE_W   = 8,
  parameter int unsigned ID_W     = 128,
  parameter int unsigned N        = 256,
  parameter logic [PRE_W-1:0] PREAMBLE = 6'b101101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TYPE_W-1:0] ftype,
  input  logic [ID_W-1:0]   fid,
  input  logic              take,
  output logic              stg_valid,
  output logic [N-1:0]      stg_u
);

  localparam int unsigned HEAD_W = PRE_W + TYPE_W + ID_W;
  localparam int unsigned K      = HEAD_W + CRC_W;
  localparam int unsigned LOG2N  = $clog2(N);

  // Keystream bit j for payload bit j
  function automatic logic [K-1:0] gen_keystream();
    logic [K-1:0] ks;
    logic [6:0]   r;
    r = LFSR_SEED;
    for (int j = 0; j < K; j++) begin
      ks[j] = lfsr_out(r);
      r     = lfsr_next(r);
    end
    return ks;
  endfunction

  // Information set: heaviest indices first, larger index wins a tie
  function automatic logic [N-1:0] gen_info_mask();
    logic [N-1:0] m;
    int cnt;
    int w;
    m   = '0;
    cnt = 0;
    for (int wt = LOG2N; wt >= 0; wt--) begin
      for (int i = N - 1; i >= 0; i--) begin
        w = 0;
        for (int b = 0; b < LOG2N; b++) w = w + ((i >> b) & 1);
        if (w == wt && cnt < K) begin
          m[i] = 1'b1;
          cnt  = cnt + 1;
        end
      end
    end
    return m;
  endfunction

  localparam logic [K-1:0] KEYSTREAM = gen_keystream();
  localparam logic [N-1:0] INFO_MASK = gen_info_mask();

  logic [HEAD_W-1:0] head;
  logic [15:0]       crc;
  logic [K-1:0]      frame;
  logic [K-1:0]      sbits;
  logic [N-1:0]      u_build;
  logic              accept;
  logic              stg_valid_d;

  // Payload, CRC, whitening and placement
  always_comb begin
    int j;
    head = {PREAMBLE, ftype, fid};
    crc  = CRC_INIT;
    for (int b = 0; b < int'(HEAD_W); b++) crc = crc16_step(crc, head[HEAD_W-1-b]);
    frame = {head, crc};
    for (int k = 0; k < int'(K); k++) sbits[k] = frame[K-1-k] ^ KEYSTREAM[k];
    u_build = '0;
    j = 0;
    for (int i = 0; i < int'(N); i++) begin
      if (INFO_MASK[i]) begin
        u_build[i] = sbits[j];
        j = j + 1;
      end
    end
  end

  assign accept      = start & ~stg_valid;
  assign stg_valid_d = accept | (stg_valid & ~take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_valid <= 1'b0;
    else        stg_valid <= stg_valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) stg_u <= u_build;
  end

  a_r7_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stg_valid && !take |=> stg_valid && $stable(stg_u));
  a_r7_accept_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    start && !stg_valid |=> stg_valid);

endmodule

// File: rtl/beacon_polar_xform.sv
module beacon_polar_xform #(
  parameter int unsigned N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] u,
  output logic [N-1:0] x
);

  localparam int unsigned LOG2N = $clog2(N);

  logic [LOG2N:0][N-1:0] st;

  assign st[0] = u;

  for (genvar s = 0; s < LOG2N; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (((i >> s) & 1) == 0) begin : g_xor
        assign st[s+1][i] = st[s][i] ^ st[s][i + (1 << s)];
      end else begin : g_pass
        assign st[s+1][i] = st[s][i];
      end
    end
  end

  assign x = st[LOG2N];

  a_r4_first_is_parity: assert property (@(posedge clk) disable iff (!rst_n)
    x[0] == ^u);
  a_r4_last_passes: assert property (@(posedge clk) disable iff (!rst_n)
    x[N-1] == u[N-1]);

endmodule

// File: rtl/beacon_serializer.sv
module beacon_serializer #(
  parameter int unsigned N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sym_tick,
  input  logic         cw_valid,
  input  logic [N-1:0] cw,
  output logic         take,
  output logic         tx_bit,
  output logic         tx_valid
);

  localparam int unsigned LOG2N = $clog2(N);
  localparam logic [LOG2N-1:0] LAST = LOG2N'(N - 1);

  logic             active_q, active_d;
  logic [LOG2N-1:0] cnt_q, cnt_d;
  logic [N-1:0]     sh_q, sh_d;
  logic             last_tick;

  assign last_tick = active_q & sym_tick & (cnt_q == LAST);
  assign take      = cw_valid & (~active_q | last_tick);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    if (take) begin
      active_d = 1'b1;
      cnt_d    = '0;
      sh_d     = cw;
    end else if (active_q && sym_tick) begin
      sh_d  = {1'b0, sh_q[N-1:1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_ff @(posedge clk) begin
    if (take || (active_q && sym_tick)) begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign tx_valid = active_q;
  assign tx_bit   = active_q & sh_q[0];

  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !sym_tick |=> active_q && $stable(tx_bit));
  a_r6_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(sym_tick));
  a_r8_gapless_handover: assert property (@(posedge clk) disable iff (!rst_n)
    take && active_q |=> active_q);

endmodule

// File: rtl/beacon_frame_enc.sv
module beacon_frame_enc #(
  parameter int unsigned PRE_W  = 6,
  parameter int unsigned TYPE_W = 8,
  parameter int unsigned ID_W   = 128,
  parameter int unsigned N      = 256,
  parameter logic [PRE_W-1:0] PREAMBLE = 6'b101101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [TYPE_W-1:0] frame_type,
  input  logic [ID_W-1:0]   frame_id,
  output logic              busy,
  input  logic              sym_tick,
  output logic              tx_bit,
  output logic              tx_valid
);

  logic [1:0]   rst_sync;
  logic         rst_s;
  logic         stg_valid;
  logic         take;
  logic [N-1:0] stg_u;
  logic [N-1:0] cw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  beacon_frame_asm #(
    .PRE_W(PRE_W), .TYPE_W(TYPE_W), .ID_W(ID_W), .N(N), .PREAMBLE(PREAMBLE)
  ) u_asm (
    .clk(clk), .rst_n(rst_s), .start(frame_start), .ftype(frame_type),
    .fid(frame_id), .take(take), .stg_valid(stg_valid), .stg_u(stg_u)
  );

  beacon_polar_xform #(.N(N)) u_polar (
    .clk(clk), .rst_n(rst_s), .u(stg_u), .x(cw)
  );

  beacon_serializer #(.N(N)) u_ser (
    .clk(clk), .rst_n(rst_s), .sym_tick(sym_tick), .cw_valid(stg_valid),
    .cw(cw), .take(take), .tx_bit(tx_bit), .tx_valid(tx_valid)
  );

  assign busy = stg_valid;

  a_r9_quiet_in_reset: assert property (@(posedge clk)
    !rst_s |=> !busy && !tx_valid);

endmodule

// File: tb/sim_beacon_frame_enc.sv
module sim_beacon_frame_enc;

  localparam int N = 256;
  localparam int K = 158;
  localparam logic [5:0] PRE = 6'b101101;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_start = 1'b0;
  logic [7:0]   frame_type = '0;
  logic [127:0] frame_id = '0;
  logic         sym_tick = 1'b0;
  logic         busy, tx_bit, tx_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  beacon_frame_enc u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_type(frame_type),
    .frame_id(frame_id), .busy(busy), .sym_tick(sym_tick), .tx_bit(tx_bit),
    .tx_valid(tx_valid)
  );

  // {tick gap, type, id}
  localparam logic [139:0] VEC [4] = '{
    {4'd0, 8'h00, 128'h0},
    {4'd2, 8'hFF, {128{1'b1}}},
    {4'd1, 8'hA5, {4{32'hDEADBEEF}}},
    {4'd0, 8'h3C, 128'h0123456789ABCDEF_FEDCBA9876543210}
  };

  function automatic logic [N-1:0] model(input logic [7:0] t, input logic [127:0] id);
    logic [K-1:0] pl;
    logic [15:0]  c;
    logic [6:0]   r;
    logic         k, fb;
    logic [N-1:0] mask, u, x;
    int cnt, w, j;
    for (int b = 0; b < 6; b++)   pl[b]      = PRE[5-b];
    for (int b = 0; b < 8; b++)   pl[6+b]    = t[7-b];
    for (int b = 0; b < 128; b++) pl[14+b]   = id[127-b];
    c = 16'hFFFF;
    for (int b = 0; b < 142; b++) begin
      fb = c[15] ^ pl[b];
      c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
    end
    for (int b = 0; b < 16; b++)  pl[142+b]  = c[15-b];
    r = 7'h7F;
    for (int b = 0; b < K; b++) begin
      k = r[6] ^ r[3];
      pl[b] = pl[b] ^ k;
      r = {r[5:0], k};
    end
    mask = '0; cnt = 0;
    for (int wt = 8; wt >= 0; wt--)
      for (int i = N - 1; i >= 0; i--) begin
        w = 0;
        for (int b = 0; b < 8; b++) w += (i >> b) & 1;
        if (w == wt && cnt < K) begin mask[i] = 1'b1; cnt++; end
      end
    u = '0; j = 0;
    for (int i = 0; i < N; i++) if (mask[i]) begin u[i] = pl[j]; j++; end
    for (int i = 0; i < N; i++) begin
      x[i] = 1'b0;
      for (int q = 0; q < N; q++) if ((q & i) == i) x[i] ^= u[q];
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] t, input logic [127:0] id);
    while (busy) @(negedge clk);
    frame_type = t; frame_id = id; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wait_valid();
    int w = 0;
    while (!tx_valid && w < 1000) begin @(negedge clk); w++; end
  endtask

  // Collect one codeword; counts ticks seen without tx_valid and hold violations
  task automatic receive(input int gap, output logic [N-1:0] got, output int lost, output int moved);
    logic b;
    lost = 0; moved = 0;
    for (int k = 0; k < N; k++) begin
      if (!tx_valid) lost++;
      got[k] = tx_bit;
      sym_tick = 1'b1;
      @(negedge clk);
      sym_tick = 1'b0;
      b = tx_bit;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (tx_bit !== b) moved++;
      end
    end
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] got, exp, got2, exp2;
    int lost, moved;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9 busy", N'(busy), '0);
    check(tx_valid == 1'b0, "R9 tx_valid", N'(tx_valid), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && tx_valid == 1'b0, "R9 after release", N'({busy, tx_valid}), '0);

    // Table walk: R1 R2 R3 R4 codeword content, R5 order and hold, R6 length
    for (int v = 0; v < 4; v++) begin
      exp = model(VEC[v][135:128], VEC[v][127:0]);
      send(VEC[v][135:128], VEC[v][127:0]);
      wait_valid();
      receive(int'(VEC[v][139:136]), got, lost, moved);
      check(got === exp, "R1 R2 R3 R4 R5 codeword", got, exp);
      check(lost == 0 && moved == 0, "R5 R6 valid and hold", N'({lost, moved}), '0);
      @(negedge clk);
      check(tx_valid == 1'b0, "R6 valid drops after 256 ticks", N'(tx_valid), '0);
    end

    // R7 R8: stage a frame behind a running one, offer a third while busy
    exp  = model(8'h11, 128'h1);
    exp2 = model(8'h22, 128'h2);
    send(8'h11, 128'h1);
    wait_valid();
    send(8'h22, 128'h2);
    @(negedge clk);
    check(busy == 1'b1, "R7 busy while staged", N'(busy), N'(1));
    frame_type = 8'h33; frame_id = 128'h3; frame_start = 1'b1;
    repeat (3) @(negedge clk);
    frame_start = 1'b0;
    receive(0, got, lost, moved);
    check(tx_valid == 1'b1, "R8 no gap at handover", N'(tx_valid), N'(1));
    receive(0, got2, lost, moved);
    check(got === exp, "R8 first codeword", got, exp);
    check(got2 === exp2 && lost == 0, "R7 R8 staged codeword", got2, exp2);
    repeat (20) @(negedge clk);
    check(tx_valid == 1'b0 && busy == 1'b0, "R7 request while busy ignored", N'({tx_valid, busy}), '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule